// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block sits beside one processor's memory port and tracks a single atomic reservation for a linked-load / conditional-store pair. When the processor issues a linked load, the monitor records the word address being read. When the processor later issues a conditional store, the monitor decides in the same cycle whether the store may reach memory. It also supplies the value the processor writes into the destination register: 1 when the store went ahead, 0 when it did not.

Any event that could let another party modify the reserved word between the linked read and the conditional write cancels the reservation. These events are a store reported on one of the snoop inputs (stores from other agents), an ordinary store by the same processor, a newer linked load to another word, or the conditional store itself. Matching is done on whole words: the two lowest address bits never take part in a comparison. The block does not hold memory. It only grants or withholds the write.

Top module: `rsv_monitor`

## Requirements
- R1: After synchronous reset, and after any later reset, no reservation is held: a conditional store issued next fails.
- R2: A linked load (op code 2) followed by a conditional store (op code 3) to the same word, with no cancelling event between them, succeeds: `sc_done`=1, `sc_write`=1, `sc_rd_value`=1 in the cycle of the store.
- R3: A failed conditional store gives `sc_done`=1, `sc_write`=0, `sc_rd_value`=0. `sc_rd_value` is 1 exactly when `sc_write` is 1.
- R4: A valid snoop on any snoop slot that addresses the reserved word cancels the reservation.
- R5: A valid snoop to a different word leaves the reservation intact. A snoop slot whose valid bit is 0 has no effect, whatever its address.
- R6: Address bits [1:0] are ignored in every comparison, whether request against reservation or snoop against reservation.
- R7: A conditional store to a word other than the reserved one fails.
- R8: Every conditional store cancels the reservation, whether it succeeds or fails, so a second conditional store without a new linked load fails.
- R9: An ordinary store (op code 1) by the processor to the reserved word cancels the reservation. An ordinary store to another word does not.
- R10: A new linked load replaces the previous reservation. The old word is no longer reserved.
- R11: A snoop to the same word in the same cycle as a conditional store makes that store fail. A snoop to the same word in the same cycle as a linked load leaves no reservation.
- R12: When no conditional store is requested (`req_valid`=0, or op code 0 for a plain load, or op code 1), `sc_done`, `sc_write` and `sc_rd_value` are all 0. A plain load leaves the reservation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | ADDR_W | Byte address of the request |
| snoop_valid | input | N_SNOOP | One bit per snoop slot: another agent stores this cycle |
| snoop_addr | input | N_SNOOP*ADDR_W | Snoop byte addresses, slot 0 in the low bits |
| sc_done | output | 1 | A conditional store is being answered this cycle |
| sc_write | output | 1 | The conditional store may write memory |
| sc_rd_value | output | XLEN | Value for the destination register (1 or 0) |

## Verification
The reservation is internal, so the only way to see it is through the verdict on a later conditional store. A reservation left set when it should have been cleared shows up as a false `sc_write`=1 on the very next conditional store to that word. That breaks atomicity silently unless the test places such a store right after each cancelling event. A reservation cleared when it should have survived shows up as a spurious 0 in `sc_rd_value`, which looks like a retry loop that never ends. The vector sequence therefore follows every cancelling or non-cancelling event with a conditional store one or two cycles later. The verdict is combinational, so each error appears in the same cycle as the store it concerns.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } rsv_op_e;

    // byte-offset bits inside one word; excluded from every match
    localparam int WORD_OFS_BITS = 2;

    function automatic logic op_is(input logic [1:0] raw, input rsv_op_e kind);
        return rsv_op_e'(raw) == kind;
    endfunction

endpackage

// File: rtl/rsv_word_cmp.sv
module rsv_word_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_word
);
    import rsv_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << WORD_OFS_BITS) - ADDR_W'(1));

    assign same_word = ((addr_a ^ addr_b) & WORD_MASK) == '0;

endmodule

// File: rtl/rsv_snoop_bank.sv
module rsv_snoop_bank #(
    parameter int ADDR_W  = 16,
    parameter int N_SNOOP = 2
) (
    input  logic [N_SNOOP-1:0]        snp_valid,
    input  logic [N_SNOOP*ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-1:0]         ref_addr,
    output logic                      any_hit
);
    logic [N_SNOOP-1:0] slot_match;
    logic [N_SNOOP-1:0] slot_hit;

    for (genvar s = 0; s < N_SNOOP; s++) begin : g_slot
        rsv_word_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .addr_a   (snp_addr[s*ADDR_W +: ADDR_W]),
            .addr_b   (ref_addr),
            .same_word(slot_match[s])
        );
        assign slot_hit[s] = snp_valid[s] & slot_match[s];
    end

    assign any_hit = |slot_hit;

endmodule

// File: rtl/rsv_state.sv
module rsv_state #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_ok,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              kill,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } rsv_t;

    rsv_t rsv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_q <= '0;
        end else if (load_en) begin
            rsv_q.valid <= load_ok;
            rsv_q.addr  <= load_addr;
        end else if (kill) begin
            rsv_q.valid <= 1'b0;
        end
    end

    assign held      = rsv_q.valid;
    assign held_addr = rsv_q.addr;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !held); // R1

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
    parameter int ADDR_W  = 16,
    parameter int N_SNOOP = 2,
    parameter int XLEN    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [N_SNOOP-1:0]        snoop_valid,
    input  logic [N_SNOOP*ADDR_W-1:0] snoop_addr,
    output logic                      sc_done,
    output logic                      sc_write,
    output logic [XLEN-1:0]           sc_rd_value
);
    import rsv_pkg::*;

    logic              held;
    logic [ADDR_W-1:0] held_addr;
    logic              own_hit;
    logic              snp_on_held;
    logic              snp_on_req;
    logic              is_link, is_cond, is_store;
    logic              pass;
    logic              kill;

    assign is_link  = req_valid && op_is(req_op, OP_LINK);
    assign is_cond  = req_valid && op_is(req_op, OP_COND);
    assign is_store = req_valid && op_is(req_op, OP_STORE);

    rsv_word_cmp #(.ADDR_W(ADDR_W)) u_own (
        .addr_a   (req_addr),
        .addr_b   (held_addr),
        .same_word(own_hit)
    );

    rsv_snoop_bank #(.ADDR_W(ADDR_W), .N_SNOOP(N_SNOOP)) u_snp_held (
        .snp_valid(snoop_valid),
        .snp_addr (snoop_addr),
        .ref_addr (held_addr),
        .any_hit  (snp_on_held)
    );

    rsv_snoop_bank #(.ADDR_W(ADDR_W), .N_SNOOP(N_SNOOP)) u_snp_req (
        .snp_valid(snoop_valid),
        .snp_addr (snoop_addr),
        .ref_addr (req_addr),
        .any_hit  (snp_on_req)
    );

    // a same-cycle foreign store to the word defeats the store-conditional
    assign pass = is_cond && held && own_hit && !snp_on_held;
    assign kill = is_cond || (is_store && own_hit) || snp_on_held;

    rsv_state #(.ADDR_W(ADDR_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .load_en  (is_link),
        .load_ok  (!snp_on_req),
        .load_addr(req_addr),
        .kill     (kill),
        .held     (held),
        .held_addr(held_addr)
    );

    assign sc_done     = is_cond;
    assign sc_write    = pass;
    assign sc_rd_value = XLEN'(pass);

    AST_WRITE_ONLY_ON_COND: assert property (@(posedge clk) disable iff (rst)
        sc_write |-> sc_done); // R3
    AST_RESULT_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> (sc_rd_value == XLEN'(sc_write))); // R3
    AST_COND_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        sc_done |=> !held); // R8
    AST_SNOOP_CANCELS: assert property (@(posedge clk) disable iff (rst)
        (snp_on_held && !is_link) |=> !held); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!sc_done && !sc_write && sc_rd_value == '0)); // R12

endmodule

// File: tb/sim_rsv_monitor.sv
module sim_rsv_monitor;
    localparam int ADDR_W  = 16;
    localparam int N_SNOOP = 2;
    localparam int XLEN    = 32;

    typedef struct packed {
        logic        rv;
        logic [1:0]  op;
        logic [15:0] addr;
        logic [1:0]  sv;
        logic [15:0] sa0;
        logic [15:0] sa1;
        logic        ed;
        logic        ew;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    // op: 0 load, 1 store, 2 linked load, 3 conditional store
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 16'h0100, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd2},  // R2 link
        '{1'b1, 2'd3, 16'h0100, 2'b00, 16'h0, 16'h0, 1'b1, 1'b1, 4'd2},  // R2 success
        '{1'b1, 2'd3, 16'h0100, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd8},  // R8 second cond fails
        '{1'b1, 2'd2, 16'h0200, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 2'd0, 16'h0000, 2'b01, 16'h0204, 16'h0, 1'b0, 1'b0, 4'd5}, // R5 other word snoop
        '{1'b1, 2'd3, 16'h0203, 2'b00, 16'h0, 16'h0, 1'b1, 1'b1, 4'd6},  // R6 low bits ignored
        '{1'b1, 2'd2, 16'h0300, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd4},
        '{1'b0, 2'd0, 16'h0000, 2'b10, 16'h0, 16'h0302, 1'b0, 1'b0, 4'd4}, // R4 slot1 hit
        '{1'b1, 2'd3, 16'h0300, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd4},  // R4 fails
        '{1'b1, 2'd2, 16'h0400, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd7},
        '{1'b1, 2'd3, 16'h0404, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd7},  // R7 other word
        '{1'b1, 2'd3, 16'h0400, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd8},  // R8 failed cond consumed
        '{1'b1, 2'd2, 16'h0500, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 2'd1, 16'h0504, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd9},  // R9 store other word
        '{1'b1, 2'd0, 16'h0500, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd12}, // R12 plain load
        '{1'b1, 2'd3, 16'h0501, 2'b00, 16'h0, 16'h0, 1'b1, 1'b1, 4'd9},  // R9 survived
        '{1'b1, 2'd2, 16'h0600, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 2'd1, 16'h0602, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd9},  // R9 own store cancels
        '{1'b1, 2'd3, 16'h0600, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd9},
        '{1'b1, 2'd2, 16'h0700, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd10},
        '{1'b1, 2'd2, 16'h0800, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd10},
        '{1'b1, 2'd3, 16'h0700, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd10}, // R10 old word gone
        '{1'b1, 2'd2, 16'h0900, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 2'd3, 16'h0900, 2'b01, 16'h0901, 16'h0, 1'b1, 1'b0, 4'd11}, // R11 race on cond
        '{1'b1, 2'd2, 16'h0A00, 2'b10, 16'h0, 16'h0A01, 1'b0, 1'b0, 4'd11}, // R11 race on link
        '{1'b1, 2'd3, 16'h0A00, 2'b00, 16'h0, 16'h0, 1'b1, 1'b0, 4'd11},
        '{1'b1, 2'd2, 16'h0B00, 2'b00, 16'h0, 16'h0, 1'b0, 1'b0, 4'd5},
        '{1'b0, 2'd3, 16'h0B00, 2'b00, 16'h0B00, 16'h0B00, 1'b0, 1'b0, 4'd5}, // R5 invalid snoop, R12
        '{1'b1, 2'd3, 16'h0B00, 2'b00, 16'h0, 16'h0, 1'b1, 1'b1, 4'd5}
    };

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic [1:0]                req_op = 2'd0;
    logic [ADDR_W-1:0]         req_addr = '0;
    logic [N_SNOOP-1:0]        snoop_valid = '0;
    logic [N_SNOOP*ADDR_W-1:0] snoop_addr = '0;
    logic                      sc_done;
    logic                      sc_write;
    logic [XLEN-1:0]           sc_rd_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rsv_monitor #(.ADDR_W(ADDR_W), .N_SNOOP(N_SNOOP), .XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .sc_done(sc_done), .sc_write(sc_write), .sc_rd_value(sc_rd_value)
    );

    task automatic drive(input logic rv, input logic [1:0] op, input logic [15:0] a,
                         input logic [1:0] sv, input logic [15:0] s0, input logic [15:0] s1);
        @(negedge clk);
        req_valid   = rv;
        req_op      = op;
        req_addr    = a;
        snoop_valid = sv;
        snoop_addr  = {s1, s0};
        #5;
    endtask

    task automatic check(input int req, input logic ed, input logic ew);
        logic [XLEN-1:0] ev;
        ev = XLEN'(ew);
        n_checks++;
        if (sc_done !== ed || sc_write !== ew || sc_rd_value !== ev) begin
            n_fail++;
            $display("FAIL R%0d: done/write/value = %b/%b/%0h, expected %b/%b/%0h",
                     req, sc_done, sc_write, sc_rd_value, ed, ew, ev);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: conditional store right after reset fails
        drive(1'b1, 2'd3, 16'h0000, 2'b00, 16'h0, 16'h0);
        check(1, 1'b1, 1'b0);
        // R12: idle cycle is quiet
        drive(1'b0, 2'd0, 16'h0000, 2'b00, 16'h0, 16'h0);
        check(12, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].rv, VECS[i].op, VECS[i].addr, VECS[i].sv, VECS[i].sa0, VECS[i].sa1);
            check(int'(VECS[i].req), VECS[i].ed, VECS[i].ew);
        end

        // R1: reset in the middle drops a live reservation
        drive(1'b1, 2'd2, 16'h0C00, 2'b00, 16'h0, 16'h0);
        check(1, 1'b0, 1'b0);
        drive(1'b0, 2'd0, 16'h0000, 2'b00, 16'h0, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 2'd3, 16'h0C00, 2'b00, 16'h0, 16'h0);
        check(1, 1'b1, 1'b0);

        // R2/R6: link with offset 3, cond with offset 0, top address word
        drive(1'b1, 2'd2, 16'hFFFF, 2'b00, 16'h0, 16'h0);
        check(6, 1'b0, 1'b0);
        drive(1'b1, 2'd3, 16'hFFFC, 2'b00, 16'h0, 16'h0);
        check(2, 1'b1, 1'b1);

        drive(1'b0, 2'd0, 16'h0000, 2'b00, 16'h0, 16'h0);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R0: watchdog expired, actual hung, expected completion");
        finish_run();
    end

endmodule